// File: doc/BRIEF.md
# DMA Channel Work-Unit Sequencer

This block is the control core of a single DMA channel. Software programs a start address, an inner count and signed inner stride, an outer count and signed outer stride, and then a 16-bit configuration word. Setting the enable bit launches a work unit. The block then presents one transfer at a time on a request/acknowledge port, with the address, the word size and the direction. Each acknowledged beat moves the address to the next element. The work unit is either a single linear run or a grid of rows.

When a work unit ends, the channel either stops and reports completion or, in repeating mode, reloads its start values and runs again. A synchronized variant of repeating mode leaves a one-cycle gap first. A data-interrupt pulse can mark each finished row or the whole work unit. A sticky error flag reports illegal enables and any attempt to reconfigure a running channel. Descriptor fetching and the data path belong to neighbouring blocks, and descriptor flow codes behave as stop here.

Top module: `dmaseq_channel`

## Requirements
- R1: After reset the configuration is 0x0000 and `busy`, `req`, `irq`, `err` and `done` are all 0.
- R2: The configuration word is written with `wr_sel`=0 and uses these fields: bit 0 enable, bit 1 direction (1 = memory write, driven on `req_write`), bits 3:2 word size (00 8-bit, 01 16-bit, 10 32-bit, driven on `req_size`), bit 4 two-dimensional mode, bit 5 synchronized reload, bit 6 interrupt per row, bit 7 interrupt enable, bits 11:8 next-descriptor size, bits 14:12 flow. A legal enable from idle makes `busy` and `req` high in the cycle after the write edge. A beat is a cycle with `req` and `ack` both high.
- R3: Shadow registers are written with `wr_sel` 1 (start address), 2 (inner count), 3 (inner stride), 4 (outer count) and 5 (outer stride). Counts are at least 1 and strides are signed byte offsets. In linear mode the first request carries the start address, each beat adds the inner stride, and the unit holds inner-count beats.
- R4: In two-dimensional mode the unit holds outer-count rows of inner-count beats. The last beat of a row adds the outer stride in place of the inner stride.
- R5: With flow 0, 4, 6 or 7, the cycle after the final beat shows `busy`=0, `req`=0 and `done`=1.
- R6: With flow 1 and bit 5 at 0, the cycle after the final beat shows `req` high with the start address again.
- R7: With flow 1 and bit 5 at 1, the cycle after the final beat shows `req` low. The next cycle shows `req` high with the start address.
- R8: With bit 7 at 0, `irq` stays low. In linear mode with bit 7 at 1, `irq` pulses once, in the cycle after the final beat, whatever the value of bit 6.
- R9: In two-dimensional mode with bit 7 at 1, bit 6 at 1 pulses `irq` in the cycle after every row's last beat. Bit 6 at 0 pulses it only after the final beat.
- R10: While `busy` is 1, a configuration write halts the channel. With bit 0 at 0 it leaves `err` at 0. With bit 0 at 1 it sets `err`. In both cases the other configuration fields (`req_size`, `req_write`) keep their values.
- R11: An enable whose word size is 11, or whose flow is 0 or 1 with a nonzero next-descriptor size, sets `err` and leaves `busy` and `req` at 0.
- R12: `err` and `done` hold until a status write (`wr_sel`=6) with data bit 0 (clears `err`) or bit 1 (clears `done`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 config, 1 start, 2 inner count, 3 inner stride, 4 outer count, 5 outer stride, 6 status) |
| wr_data | input | AW | Write data |
| req | output | 1 | Transfer request |
| ack | input | 1 | Transfer acknowledge; a beat completes when `req` and `ack` are both high |
| req_addr | output | AW | Address of the current transfer |
| req_size | output | 2 | Word size code of the transfer |
| req_write | output | 1 | Direction: 1 memory write, 0 memory read |
| irq | output | 1 | Data-interrupt pulse |
| busy | output | 1 | Channel enable state |
| err | output | 1 | Sticky error flag |
| done | output | 1 | Sticky completion flag for stop-type flows |

## Verification
The assertions assume that `ack` is high only while `req` is high. They also assume that every count written is nonzero. Under those conditions, address holding during stalls and the spacing of the interrupt behind beats are well defined. The stimulus decides `ack` on the falling edge from the current `req`, with a random three-in-four acceptance. It draws inner counts from 1 to 6 and outer counts from 1 to 4, so it never writes a zero count.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  localparam logic [2:0] SEL_CFG   = 3'd0;
  localparam logic [2:0] SEL_START = 3'd1;
  localparam logic [2:0] SEL_ICNT  = 3'd2;
  localparam logic [2:0] SEL_ISTR  = 3'd3;
  localparam logic [2:0] SEL_OCNT  = 3'd4;
  localparam logic [2:0] SEL_OSTR  = 3'd5;
  localparam logic [2:0] SEL_STAT  = 3'd6;

  localparam logic [2:0] FLOW_STOP = 3'd0;
  localparam logic [2:0] FLOW_AUTO = 3'd1;

  typedef struct packed {
    logic       spare;
    logic [2:0] flow;
    logic [3:0] ndsz;
    logic       irq_en;
    logic       irq_row;
    logic       sync;
    logic       two_dim;
    logic [1:0] width;
    logic       dir;
    logic       run;
  } cfg_t;

  typedef enum logic [1:0] {PH_IDLE, PH_MOVE, PH_PAUSE} phase_e;

  // An enable request carrying an illegal combination of fields.
  function automatic logic cfg_fault(input cfg_t c);
    return (c.width == 2'b11) ||
           (((c.flow == FLOW_STOP) || (c.flow == FLOW_AUTO)) && (c.ndsz != 4'd0));
  endfunction

  function automatic logic flow_repeats(input cfg_t c);
    return c.flow == FLOW_AUTO;
  endfunction

endpackage

// File: rtl/dmaseq_ctrl.sv
module dmaseq_ctrl
  import dmaseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [15:0] wr_data,
  input  logic        unit_end,
  output cfg_t        cfg_q,
  output logic        start,
  output logic        err,
  output logic        done
);

  cfg_t cfg_r;
  cfg_t wr_cfg;
  logic cfg_wr, stat_wr, lock_fault, enable_fault, finish;

  assign wr_cfg       = cfg_t'(wr_data);
  assign cfg_wr       = wr_en && (wr_sel == SEL_CFG);
  assign stat_wr      = wr_en && (wr_sel == SEL_STAT);
  assign lock_fault   = cfg_wr && cfg_r.run && wr_cfg.run;
  assign enable_fault = cfg_wr && !cfg_r.run && wr_cfg.run && cfg_fault(wr_cfg);
  assign start        = cfg_wr && !cfg_r.run && wr_cfg.run && !cfg_fault(wr_cfg);
  assign finish       = unit_end && cfg_r.run && !flow_repeats(cfg_r);
  assign cfg_q        = cfg_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_r <= '0;
      err   <= 1'b0;
      done  <= 1'b0;
    end else begin
      if (cfg_wr) begin
        if (cfg_r.run) begin
          cfg_r.run <= 1'b0;           // locked: any write halts the channel
        end else begin
          cfg_r <= wr_cfg;
          if (enable_fault) cfg_r.run <= 1'b0;
        end
      end else if (finish) begin
        cfg_r.run <= 1'b0;
      end

      if (lock_fault || enable_fault) err <= 1'b1;
      else if (stat_wr && wr_data[0]) err <= 1'b0;

      if (finish) done <= 1'b1;
      else if (stat_wr && wr_data[1]) done <= 1'b0;
    end
  end

endmodule

// File: rtl/dmaseq_walker.sv
module dmaseq_walker
  import dmaseq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          start,
  input  logic          run,
  input  logic          two_dim,
  input  logic          irq_en,
  input  logic          irq_row,
  input  logic          sync,
  input  logic          repeats,
  input  logic          ack,
  output logic          req,
  output logic [AW-1:0] req_addr,
  output logic          beat,
  output logic          row_end,
  output logic          unit_end,
  output logic          irq
);

  logic [AW-1:0] start_r, addr;
  logic [CW-1:0] icnt_r, ocnt_r, col_left, row_left;
  logic [SW-1:0] istr_r, ostr_r;
  phase_e        phase;
  logic          last_col, last_row;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a,
                                               input logic [SW-1:0] s);
    return a + {{(AW-SW){s[SW-1]}}, s};
  endfunction

  assign req      = run && (phase == PH_MOVE);
  assign beat     = req && ack;
  assign last_col = (col_left == CW'(1));
  assign last_row = !two_dim || (row_left == CW'(1));
  assign row_end  = beat && last_col;
  assign unit_end = row_end && last_row;
  assign req_addr = addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_r <= '0;
      icnt_r  <= '0;
      ocnt_r  <= '0;
      istr_r  <= '0;
      ostr_r  <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_START) start_r <= wr_data;
      if (wr_sel == SEL_ICNT)  icnt_r  <= wr_data[CW-1:0];
      if (wr_sel == SEL_ISTR)  istr_r  <= wr_data[SW-1:0];
      if (wr_sel == SEL_OCNT)  ocnt_r  <= wr_data[CW-1:0];
      if (wr_sel == SEL_OSTR)  ostr_r  <= wr_data[SW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      addr     <= '0;
      col_left <= '0;
      row_left <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= irq_en && (unit_end || (two_dim && irq_row && row_end));
      if (start) begin
        addr     <= start_r;
        col_left <= icnt_r;
        row_left <= ocnt_r;
        phase    <= PH_MOVE;
      end else if (!run) begin
        phase <= PH_IDLE;
      end else begin
        case (phase)
          PH_MOVE: begin
            if (unit_end) begin
              if (!repeats) begin
                phase <= PH_IDLE;
              end else if (sync) begin
                phase <= PH_PAUSE;
              end else begin
                addr     <= start_r;
                col_left <= icnt_r;
                row_left <= ocnt_r;
              end
            end else if (row_end) begin
              addr     <= step_addr(addr, ostr_r);
              col_left <= icnt_r;
              row_left <= row_left - CW'(1);
            end else if (beat) begin
              addr     <= step_addr(addr, istr_r);
              col_left <= col_left - CW'(1);
            end
          end
          PH_PAUSE: begin
            addr     <= start_r;
            col_left <= icnt_r;
            row_left <= ocnt_r;
            phase    <= PH_MOVE;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dmaseq_channel.sv
module dmaseq_channel
  import dmaseq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  output logic          req,
  input  logic          ack,
  output logic [AW-1:0] req_addr,
  output logic [1:0]    req_size,
  output logic          req_write,
  output logic          irq,
  output logic          busy,
  output logic          err,
  output logic          done
);

  cfg_t cfg_q;
  logic start, beat, row_end, unit_end;
  logic irq_armed, err_clear_req;

  dmaseq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data[15:0]),
    .unit_end (unit_end),
    .cfg_q    (cfg_q),
    .start    (start),
    .err      (err),
    .done     (done)
  );

  dmaseq_walker #(.AW(AW), .CW(CW), .SW(SW)) u_walker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .start    (start),
    .run      (cfg_q.run),
    .two_dim  (cfg_q.two_dim),
    .irq_en   (cfg_q.irq_en),
    .irq_row  (cfg_q.irq_row),
    .sync     (cfg_q.sync),
    .repeats  (flow_repeats(cfg_q)),
    .ack      (ack),
    .req      (req),
    .req_addr (req_addr),
    .beat     (beat),
    .row_end  (row_end),
    .unit_end (unit_end),
    .irq      (irq)
  );

  assign busy          = cfg_q.run;
  assign req_size      = cfg_q.width;
  assign req_write     = cfg_q.dir;
  assign irq_armed     = cfg_q.irq_en;
  assign err_clear_req = wr_en && (wr_sel == SEL_STAT) && wr_data[0];

endmodule

// File: rtl/dmaseq_checks.sv
module dmaseq_checks #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          ack,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_size,
  input logic          req_write,
  input logic          irq,
  input logic          busy,
  input logic          err,
  input logic          done,
  input logic          beat,
  input logic          irq_armed,
  input logic          err_clear_req
);

  p_ack_with_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> req);

  p_req_needs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> busy);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> $stable(req_addr));

  p_irq_after_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(beat) && $past(irq_armed)));

  p_cfg_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(req_size) && $stable(req_write)));

  p_err_halts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy);

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clear_req) |=> err);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && !req));

endmodule

bind dmaseq_channel dmaseq_checks #(.AW(AW)) u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .req           (req),
  .ack           (ack),
  .req_addr      (req_addr),
  .req_size      (req_size),
  .req_write     (req_write),
  .irq           (irq),
  .busy          (busy),
  .err           (err),
  .done          (done),
  .beat          (beat),
  .irq_armed     (irq_armed),
  .err_clear_req (err_clear_req)
);

// File: tb/test_dmaseq_channel.sv
module test_dmaseq_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        ack = 1'b0;
  logic        req, req_write, irq, busy, err, done;
  logic [31:0] req_addr;
  logic [1:0]  req_size;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dmaseq_channel i_dmaseq_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req(req), .ack(ack), .req_addr(req_addr), .req_size(req_size),
    .req_write(req_write), .irq(irq), .busy(busy), .err(err), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    ack = 1'b0; wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] mk_cfg(int flow, int ndsz, int ien, int isel,
                                         int sync, int td, int w, int dir, int en);
    return {1'b0, 3'(flow), 4'(ndsz), 1'(ien), 1'(isel), 1'(sync), 1'(td),
            2'(w), 1'(dir), 1'(en)};
  endfunction

  // Address of beat k: whole rows first, then the column offset.
  function automatic logic [31:0] exp_addr(int st, int ic, int is, int os, int k);
    int row = k / ic;
    int col = k % ic;
    return 32'(st + row * ((ic - 1) * is + os) + col * is);
  endfunction

  task automatic run_job(int flow, int ndsz, int ien, int isel, int sync, int td,
                         int w, int dir, int st, int ic, int is, int oc, int os,
                         int units);
    int total = td ? ic * oc : ic;
    int k = 0;
    int got = 0;
    logic pend = 1'b0;
    logic fin = 1'b0;
    logic row_e, unit_e, exp_irq;
    wr(3'd1, st); wr(3'd2, ic); wr(3'd3, is); wr(3'd4, oc); wr(3'd5, os);
    wr(3'd0, {16'd0, mk_cfg(flow, ndsz, ien, isel, sync, td, w, dir, 1)});
    chk("R2 busy after enable", busy, 1);
    chk("R2 req after enable", req, 1);
    chk("R2 size field", req_size, w);
    chk("R2 direction field", req_write, dir);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (pend) begin
        pend = 1'b0;
        row_e = ((k + 1) % ic) == 0;
        unit_e = (k + 1) == total;
        exp_irq = ien && (unit_e || (td && isel && row_e));
        chk(td ? "R9 irq" : "R8 irq", irq, exp_irq);
        k++;
        if (unit_e) begin
          k = 0;
          got++;
          if (flow != 1) begin
            chk("R5 busy clears", busy, 0);
            chk("R5 req low", req, 0);
            chk("R5 done set", done, 1);
            fin = 1'b1;
          end else if (sync) begin
            chk("R7 gap cycle", req, 0);
          end else begin
            chk("R6 immediate reload", req, 1);
          end
          if (got == units) fin = 1'b1;
        end
      end else begin
        chk("R8 irq idle", irq, 0);
      end
      if (fin) break;
      if (req) chk(td ? "R4 address" : "R3 address", req_addr, exp_addr(st, ic, is, os, k));
      ack = req && (($urandom % 4) != 0);
      pend = ack;
      @(negedge clk);
    end
    ack = 1'b0;
    chk("R5 units completed", got, units);
    if (flow == 1) begin
      wr(3'd0, 32'd0);
      chk("R10 halt busy", busy, 0);
      chk("R10 halt req", req, 0);
      chk("R10 halt no err", err, 0);
    end else begin
      wr(3'd6, 32'd2);
      chk("R12 done cleared", done, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog: cycles=200000 expected fewer");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 req", req, 0); chk("R1 irq", irq, 0);
    chk("R1 err", err, 0); chk("R1 done", done, 0);
    chk("R1 size", req_size, 0); chk("R1 dir", req_write, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Linear stop, row timing bit set but ignored (R8).
    run_job(0, 0, 1, 1, 0, 0, 0, 0, 32'h1000, 5, 1, 3, 100, 1);
    // 2-D stop, per-row interrupt, negative strides.
    run_job(0, 0, 1, 1, 0, 1, 2, 1, 32'h8000, 3, -4, 3, 40, 1);
    // 2-D stop, interrupt at whole buffer only.
    run_job(0, 0, 1, 0, 0, 1, 1, 0, 32'h200, 4, 2, 3, -30, 1);
    // Descriptor flow codes behave as stop; ndsz is not checked there.
    run_job(4, 5, 1, 0, 0, 0, 0, 1, 32'h40, 2, 8, 1, 0, 1);
    run_job(6, 9, 0, 0, 0, 1, 2, 0, 32'h50, 2, 4, 2, 16, 1);
    run_job(7, 1, 1, 1, 1, 1, 1, 1, 32'h60, 1, 4, 3, 12, 1);
    // Autobuffer, continuous and synchronized reload.
    run_job(1, 0, 0, 0, 0, 1, 2, 0, 32'h3000, 3, 4, 2, 64, 2);
    run_job(1, 0, 1, 0, 1, 0, 0, 1, 32'h4000, 4, 1, 1, 0, 3);
    run_job(1, 0, 1, 1, 1, 1, 1, 0, 32'h5000, 1, 2, 2, 8, 2);

    // R11: reserved word size.
    wr(3'd0, {16'd0, mk_cfg(0, 0, 0, 0, 0, 0, 3, 0, 1)});
    chk("R11 err on size 11", err, 1);
    chk("R11 not busy", busy, 0);
    chk("R11 no req", req, 0);
    repeat (3) @(negedge clk);
    chk("R12 err sticky", err, 1);
    wr(3'd6, 32'd1);
    chk("R12 err cleared", err, 0);
    // R11: nonzero descriptor size in autobuffer.
    wr(3'd0, {16'd0, mk_cfg(1, 2, 0, 0, 0, 0, 0, 0, 1)});
    chk("R11 err on ndsz", err, 1);
    chk("R11 not busy ndsz", busy, 0);
    wr(3'd6, 32'd1);

    // R10: reconfigure while running with enable set.
    wr(3'd2, 20);
    wr(3'd0, {16'd0, mk_cfg(0, 0, 0, 0, 0, 0, 1, 1, 1)});
    chk("R10 running", busy, 1);
    wr(3'd0, {16'd0, mk_cfg(0, 0, 0, 0, 0, 0, 2, 0, 1)});
    chk("R10 err on locked write", err, 1);
    chk("R10 halted", busy, 0);
    chk("R10 req low", req, 0);
    chk("R10 size kept", req_size, 1);
    chk("R10 dir kept", req_write, 1);
    wr(3'd6, 32'd1);
    // R10: write with enable cleared halts without error.
    wr(3'd0, {16'd0, mk_cfg(0, 0, 0, 0, 0, 0, 2, 1, 1)});
    chk("R10 running again", busy, 1);
    wr(3'd0, 32'd0);
    chk("R10 disable halts", busy, 0);
    chk("R10 disable no err", err, 0);
    chk("R10 disable size kept", req_size, 2);

    // Constrained random jobs.
    for (int j = 0; j < 12; j++) begin
      int flows[5] = '{0, 1, 4, 6, 7};
      int fl = flows[$urandom % 5];
      int nd = (fl <= 1) ? 0 : 1 + ($urandom % 9);
      run_job(fl, nd, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
              $urandom % 3, $urandom % 2, $urandom, 1 + ($urandom % 6),
              int'($urandom % 128) - 64, 1 + ($urandom % 4),
              int'($urandom % 128) - 64, (fl == 1) ? 2 : 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule